// File: doc/BRIEF.md
# Power Button Sleep-State Controller

This block watches an already debounced, active-low power button and keeps track of a reduced system power state. The states are working (S0), suspend-to-RAM (S3), suspend-to-disk (S4), soft-off (S5) and no-power (G3). A button press does one of three things, depending on the current state. In the working state it raises a software interrupt request. From any sleep or soft-off state it wakes the system. In no-power it does nothing.

A hold timer runs from a prescaled tick input. If the button stays pressed long enough in the working state, the block forces soft-off. This forced power-down waits for no acknowledgement from any other part of the chip. While a minimum sleep-signal stretch is running, the button is not a wake source and the hold timer is held at zero.

State encoding on `state_o`: G3 = 3'd0, S0 = 3'd1, S3 = 3'd3, S4 = 3'd4, S5 = 3'd5. The named transitions are:

- **Power-arrive**: G3 to S5 while `mains_ok_i` is high.
- **Power-loss**: any state to G3 while `mains_ok_i` is low. This has the highest priority.
- **Sleep-enter**: S0 to S3, S4 or S5 on a software sleep request.
- **Button-wake**: S3, S4 or S5 to S0 on a button press.
- **Hold-override**: S0 to S5 when the hold timer expires.

Top module: `pwrbtn_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes G3 (3'd0), the hold count becomes zero, and `irq_o`, `wake_o`, `force_off_o` and `btn_level_o` become 0.
- R2: When `mains_ok_i` is low at an edge, the next state is G3 from any state. In G3, when `mains_ok_i` is high, the next state is S5.
- R3: In S0, when `sleep_req_i` is high, `sleep_type_i` selects the next state: 2'b01 gives S3, 2'b10 gives S4, 2'b11 gives S5, and 2'b00 leaves the state at S0.
- R4: In S0, a falling edge of `btn_n_i` produces `irq_o` high for exactly one cycle, one cycle after the edge is sampled. This happens only when both `sci_en_i` and `btn_en_i` are high. The press itself commands no state change.
- R5: In S3, S4 or S5, a falling edge of `btn_n_i` sets the next state to S0, and `wake_o` is high for exactly that one cycle.
- R6: In G3, the button produces no interrupt, no wake and no override. A press that is still held when power arrives is not treated as an edge.
- R7: While `stretch_en_i` and `stretch_active_i` are both high, a press does not wake the system and the hold count stays at zero. After the stretch ends, a new press wakes the system, and an override needs a fresh full hold.
- R8: In S0, when the button has been held continuously through HOLD_TICKS tick pulses, the next state is S5 and `force_off_o` pulses high for one cycle. The enables and any handshake have no effect on this.
- R9: The hold count advances only in S0 while the button is pressed. It returns to zero on release or when the state leaves S0. One continuous hold produces at most one override.
- R10: `btn_level_o` is 1 when the button level sampled at the previous edge was pressed (`btn_n_i` low), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n_i | input | 1 | Debounced power button, low = pressed |
| tick_i | input | 1 | Prescaled one-cycle tick enable for the hold timer |
| mains_ok_i | input | 1 | Power present (low forces G3) |
| sleep_req_i | input | 1 | Software sleep request strobe |
| sleep_type_i | input | 2 | Target of a sleep request (01 S3, 10 S4, 11 S5) |
| sci_en_i | input | 1 | Global software interrupt enable |
| btn_en_i | input | 1 | Power button interrupt enable |
| stretch_en_i | input | 1 | Minimum sleep-assertion stretch enabled |
| stretch_active_i | input | 1 | Stretch timer currently running |
| state_o | output | 3 | Current power state |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| wake_o | output | 1 | One-cycle wake command pulse |
| force_off_o | output | 1 | One-cycle forced soft-off pulse |
| btn_level_o | output | 1 | Sampled button level, 1 = pressed |

## Verification
The hardest case to reach from the ports is an override that must count from zero in S0 even though the button has been held for some time. This happens after a wake with the button still held, and after a stretch window during which the button stayed pressed. Directed sequences build both situations: they press, wake, tick one short of the threshold, release or suspend the timer, then tick the full threshold again. A random phase with a short threshold, long biased holds and rare stretch windows and power drops then mixes these paths, and a bench model checks every cycle.

// File: rtl/pbsc_pkg.sv
package pbsc_pkg;

    typedef enum logic [2:0] {
        PS_G3 = 3'd0,
        PS_S0 = 3'd1,
        PS_S3 = 3'd3,
        PS_S4 = 3'd4,
        PS_S5 = 3'd5
    } pwr_state_e;

    localparam logic [1:0] SLP_NONE = 2'b00;
    localparam logic [1:0] SLP_RAM  = 2'b01;
    localparam logic [1:0] SLP_DISK = 2'b10;
    localparam logic [1:0] SLP_OFF  = 2'b11;

endpackage

// File: rtl/pbsc_btn_sense.sv
module pbsc_btn_sense (
    input  logic clk,
    input  logic rst,
    input  logic btn_n_i,
    output logic fall_o,
    output logic held_o,
    output logic level_o
);
    logic btn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_q <= 1'b1;
        end else begin
            btn_q <= btn_n_i;
        end
    end

    // sampled every cycle, in every state: a press held across power arrival is no edge
    assign fall_o  = btn_q & ~btn_n_i;
    assign held_o  = ~btn_n_i;
    assign level_o = ~btn_q;

endmodule

// File: rtl/pbsc_hold_timer.sv
module pbsc_hold_timer #(
    parameter int HOLD_TICKS = 4000,
    localparam int CNT_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             held_i,
    input  logic             tick_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    logic             fired_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run;

    assign run   = enable_i & held_i & ~fired_q;
    assign hit_o = run & tick_i & (cnt_q == LAST);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!(enable_i && held_i)) begin
            cnt_q <= '0;
        end else if (run && tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q <= 1'b0;
        end else if (!held_i) begin
            fired_q <= 1'b0;
        end else if (hit_o) begin
            fired_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pbsc_fsm.sv
module pbsc_fsm
    import pbsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mains_ok_i,
    input  logic       fall_i,
    input  logic       hit_i,
    input  logic       suppress_i,
    input  logic       sleep_req_i,
    input  logic [1:0] sleep_type_i,
    input  logic       sci_en_i,
    input  logic       btn_en_i,
    output pwr_state_e state_o,
    output logic       irq_o,
    output logic       wake_o,
    output logic       off_o
);
    pwr_state_e state_q, state_d;
    logic       irq_d, wake_d, off_d;

    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        wake_d  = 1'b0;
        off_d   = 1'b0;
        if (!mains_ok_i) begin
            state_d = PS_G3;
        end else begin
            unique case (state_q)
                PS_G3: state_d = PS_S5;
                PS_S0: begin
                    irq_d = fall_i & sci_en_i & btn_en_i;
                    if (hit_i) begin
                        state_d = PS_S5;
                        off_d   = 1'b1;
                    end else if (sleep_req_i) begin
                        unique case (sleep_type_i)
                            SLP_RAM:  state_d = PS_S3;
                            SLP_DISK: state_d = PS_S4;
                            SLP_OFF:  state_d = PS_S5;
                            default:  state_d = PS_S0;
                        endcase
                    end
                end
                PS_S3, PS_S4, PS_S5: begin
                    if (fall_i && !suppress_i) begin
                        state_d = PS_S0;
                        wake_d  = 1'b1;
                    end
                end
                default: state_d = PS_G3;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_G3;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
            off_o  <= 1'b0;
        end else begin
            irq_o  <= irq_d;
            wake_o <= wake_d;
            off_o  <= off_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/pwrbtn_sleep_ctrl.sv
module pwrbtn_sleep_ctrl
    import pbsc_pkg::*;
#(
    parameter int HOLD_TICKS = 4000,
    localparam int CNT_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_n_i,
    input  logic       tick_i,
    input  logic       mains_ok_i,
    input  logic       sleep_req_i,
    input  logic [1:0] sleep_type_i,
    input  logic       sci_en_i,
    input  logic       btn_en_i,
    input  logic       stretch_en_i,
    input  logic       stretch_active_i,
    output logic [2:0] state_o,
    output logic       irq_o,
    output logic       wake_o,
    output logic       force_off_o,
    output logic       btn_level_o
);
    pwr_state_e       cur_state;
    logic             fall, held, hit, suppress, timer_en;
    logic [CNT_W-1:0] hold_cnt;

    assign suppress = stretch_en_i & stretch_active_i;
    assign timer_en = (cur_state == PS_S0) & ~suppress;

    pbsc_btn_sense u_sense (
        .clk     (clk),
        .rst     (rst),
        .btn_n_i (btn_n_i),
        .fall_o  (fall),
        .held_o  (held),
        .level_o (btn_level_o)
    );

    pbsc_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .enable_i (timer_en),
        .held_i   (held),
        .tick_i   (tick_i),
        .hit_o    (hit),
        .cnt_o    (hold_cnt)
    );

    pbsc_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .mains_ok_i   (mains_ok_i),
        .fall_i       (fall),
        .hit_i        (hit),
        .suppress_i   (suppress),
        .sleep_req_i  (sleep_req_i),
        .sleep_type_i (sleep_type_i),
        .sci_en_i     (sci_en_i),
        .btn_en_i     (btn_en_i),
        .state_o      (cur_state),
        .irq_o        (irq_o),
        .wake_o       (wake_o),
        .off_o        (force_off_o)
    );

    assign state_o = cur_state;

endmodule

// File: rtl/pwrbtn_sleep_ctrl_chk.sv
module pwrbtn_sleep_ctrl_chk
    import pbsc_pkg::*;
#(
    parameter int HOLD_TICKS = 4000,
    localparam int CNT_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             btn_n_i,
    input logic             stretch_en_i,
    input logic             stretch_active_i,
    input logic [2:0]       state_o,
    input logic             irq_o,
    input logic             wake_o,
    input logic             force_off_o,
    input logic             btn_level_o,
    input logic [CNT_W-1:0] hold_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    AST_RESET_G3: assert property (@(posedge clk) rst |=> (state_o == PS_G3 && hold_cnt == '0)); // R1
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) irq_o |=> !irq_o); // R4
    AST_IRQ_STAYS_S0: assert property (@(posedge clk) disable iff (rst) irq_o |-> (state_o == PS_S0 || $past(state_o) == PS_S0)); // R4
    AST_WAKE_LANDS_S0: assert property (@(posedge clk) disable iff (rst) wake_o |-> state_o == PS_S0); // R5
    AST_G3_SILENT: assert property (@(posedge clk) disable iff (rst) (state_o == PS_G3) |=> (!irq_o && !wake_o && !force_off_o)); // R6
    AST_STRETCH_NO_WAKE: assert property (@(posedge clk) disable iff (rst) (stretch_en_i && stretch_active_i) |=> !wake_o); // R7
    AST_OFF_LANDS_S5: assert property (@(posedge clk) disable iff (rst) force_off_o |-> state_o == PS_S5); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) hold_cnt <= LAST); // R8
    AST_OFF_ONCE: assert property (@(posedge clk) disable iff (rst) force_off_o |=> !force_off_o); // R9
    AST_CNT_ONLY_S0: assert property (@(posedge clk) disable iff (rst) (state_o != PS_S0 || btn_n_i) |=> hold_cnt == '0); // R9
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst) !rst |=> btn_level_o == !$past(btn_n_i)); // R10

endmodule

bind pwrbtn_sleep_ctrl pwrbtn_sleep_ctrl_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .btn_n_i          (btn_n_i),
    .stretch_en_i     (stretch_en_i),
    .stretch_active_i (stretch_active_i),
    .state_o          (state_o),
    .irq_o            (irq_o),
    .wake_o           (wake_o),
    .force_off_o      (force_off_o),
    .btn_level_o      (btn_level_o),
    .hold_cnt         (hold_cnt)
);

// File: tb/tb_pwrbtn_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_pwrbtn_sleep_ctrl;
    localparam int HOLD = 8;
    localparam logic [2:0] G3 = 3'd0, S0 = 3'd1, S3 = 3'd3, S4 = 3'd4, S5 = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_n = 1'b1, tick = 1'b0, mains = 1'b0, slp_req = 1'b0;
    logic [1:0] slp_type = 2'b00;
    logic sci = 1'b0, ben = 1'b0, str_en = 1'b0, str_act = 1'b0;
    logic [2:0] state;
    logic irq, wake, off, level;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    pwrbtn_sleep_ctrl #(.HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst(rst), .btn_n_i(btn_n), .tick_i(tick), .mains_ok_i(mains),
        .sleep_req_i(slp_req), .sleep_type_i(slp_type), .sci_en_i(sci), .btn_en_i(ben),
        .stretch_en_i(str_en), .stretch_active_i(str_act), .state_o(state),
        .irq_o(irq), .wake_o(wake), .force_off_o(off), .btn_level_o(level)
    );

    // reference model built from the requirements
    logic       m_btnq, m_fired, m_irq, m_wake, m_off;
    logic [2:0] m_state;
    int         m_cnt;

    function automatic logic [2:0] sleep_target(input logic [1:0] t);
        case (t)
            2'b01:   return S3;
            2'b10:   return S4;
            2'b11:   return S5;
            default: return S0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic fall, held, sup, en, hit;
        logic [2:0] nxt;
        if (rst) begin
            m_btnq <= 1'b1; m_state <= G3; m_cnt <= 0; m_fired <= 1'b0;
            m_irq <= 1'b0; m_wake <= 1'b0; m_off <= 1'b0;
        end else begin
            fall = m_btnq && !btn_n;
            held = !btn_n;
            sup  = str_en && str_act;
            en   = (m_state == S0) && !sup;
            hit  = en && held && !m_fired && tick && (m_cnt == HOLD - 1);
            nxt  = m_state;
            m_irq <= 1'b0; m_wake <= 1'b0; m_off <= 1'b0;
            if (!mains) nxt = G3;
            else if (m_state == G3) nxt = S5;
            else if (m_state == S0) begin
                m_irq <= fall && sci && ben;
                if (hit) begin nxt = S5; m_off <= 1'b1; end
                else if (slp_req) nxt = sleep_target(slp_type);
            end else if (fall && !sup) begin
                nxt = S0; m_wake <= 1'b1;
            end
            m_state <= nxt;
            if (!(en && held)) m_cnt <= 0;
            else if (!m_fired && tick) m_cnt <= (m_cnt == HOLD - 1) ? 0 : m_cnt + 1;
            if (!held) m_fired <= 1'b0;
            else if (hit) m_fired <= 1'b1;
            m_btnq <= btn_n;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 state vs model", 32'(state), 32'(m_state));
            chk("R4 irq vs model", 32'(irq), 32'(m_irq));
            chk("R5 wake vs model", 32'(wake), 32'(m_wake));
            chk("R8 force_off vs model", 32'(off), 32'(m_off));
            chk("R10 level vs model", 32'(level), 32'(!m_btnq));
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tickp();
        tick = 1'b1; step();
        tick = 1'b0; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        chk("R1 state", 32'(state), 32'(G3));
        chk("R1 pulses", 32'({irq, wake, off, level}), 32'h0);
        rst = 1'b0; cmp_on = 1'b1;

        // R6: no power, button ignored
        btn_n = 1'b0; step(); step();
        chk("R6 state", 32'(state), 32'(G3));
        chk("R6 pulses", 32'({irq, wake, off}), 32'h0);
        // R6: press held as power arrives is not an edge
        mains = 1'b1; step();
        chk("R2 power arrive", 32'(state), 32'(S5));
        step();
        chk("R6 held at arrival", 32'(state), 32'(S5));
        btn_n = 1'b1; step();

        // R5 wake from soft-off
        btn_n = 1'b0; step();
        chk("R5 wake state", 32'(state), 32'(S0));
        chk("R5 wake pulse", 32'(wake), 32'h1);
        step();
        chk("R5 wake one cycle", 32'(wake), 32'h0);

        // R9 release clears count, R8 override
        repeat (HOLD - 1) tickp();
        chk("R9 below threshold", 32'(state), 32'(S0));
        btn_n = 1'b1; step();
        btn_n = 1'b0; step();
        chk("R4 irq disabled", 32'(irq), 32'h0);
        repeat (HOLD - 1) tickp();
        chk("R9 count restarted", 32'(state), 32'(S0));
        tick = 1'b1; step();
        chk("R8 override state", 32'(state), 32'(S5));
        chk("R8 override pulse", 32'(off), 32'h1);
        tick = 1'b0; step();
        chk("R8 pulse one cycle", 32'(off), 32'h0);
        repeat (2 * HOLD) tickp();
        chk("R9 one override per hold", 32'(state), 32'(S5));

        // R7 stretch blocks wake
        btn_n = 1'b1; step();
        str_en = 1'b1; str_act = 1'b1;
        btn_n = 1'b0; step(); step();
        chk("R7 no wake in stretch", 32'(state), 32'(S5));
        btn_n = 1'b1; str_act = 1'b0; step();
        btn_n = 1'b0; step();
        chk("R7 wake after stretch", 32'(state), 32'(S0));
        // R7 timer forced inactive, then a fresh full hold
        str_act = 1'b1;
        repeat (HOLD + 4) tickp();
        chk("R7 timer suppressed", 32'(state), 32'(S0));
        str_act = 1'b0;
        repeat (HOLD - 1) tickp();
        chk("R7 fresh hold needed", 32'(state), 32'(S0));
        tick = 1'b1; step();
        chk("R7 fresh hold fires", 32'(off), 32'h1);
        tick = 1'b0; str_en = 1'b0;

        // R4 interrupt in working state
        btn_n = 1'b1; step();
        btn_n = 1'b0; step();
        btn_n = 1'b1; step();
        sci = 1'b1; ben = 1'b1;
        btn_n = 1'b0; step();
        chk("R4 irq pulse", 32'(irq), 32'h1);
        chk("R4 no state change", 32'(state), 32'(S0));
        step();
        chk("R4 irq one cycle", 32'(irq), 32'h0);
        btn_n = 1'b1; ben = 1'b0; step();
        btn_n = 1'b0; step();
        chk("R4 btn enable off", 32'(irq), 32'h0);
        btn_n = 1'b1; step();

        // R3 sleep entries
        slp_req = 1'b1; slp_type = 2'b00; step();
        chk("R3 type none", 32'(state), 32'(S0));
        slp_type = 2'b01; step(); slp_req = 1'b0;
        chk("R3 to S3", 32'(state), 32'(S3));
        btn_n = 1'b0; step(); btn_n = 1'b1; step();
        slp_req = 1'b1; slp_type = 2'b10; step(); slp_req = 1'b0;
        chk("R3 to S4", 32'(state), 32'(S4));
        btn_n = 1'b0; step();
        chk("R5 wake from S4", 32'(state), 32'(S0));
        btn_n = 1'b1; step();
        slp_req = 1'b1; slp_type = 2'b11; step(); slp_req = 1'b0;
        chk("R3 to S5", 32'(state), 32'(S5));

        // R2 power loss
        mains = 1'b0; step();
        chk("R2 power loss", 32'(state), 32'(G3));
        mains = 1'b1; step();

        // R10 level
        btn_n = 1'b0; step();
        chk("R10 pressed", 32'(level), 32'h1);
        btn_n = 1'b1; step();
        chk("R10 released", 32'(level), 32'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 40 == 0) btn_n = ~btn_n;
            tick     = ($urandom % 3 == 0);
            mains    = ($urandom % 400 != 0);
            slp_req  = ($urandom % 50 == 0);
            slp_type = 2'($urandom);
            if ($urandom % 100 == 0) begin sci = 1'($urandom); ben = 1'($urandom); end
            if ($urandom % 200 == 0) str_en = ~str_en;
            if ($urandom % 60 == 0) str_act = ~str_act;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule